// File: doc/BRIEF.md
# Two-Pass Row-Column Odd-Basis Block Transform

This block computes a 4x4 two-dimensional integer transform as one building block of an 8x8 integer transform datapath. It takes a whole 4x4 block of signed samples in one cycle. In the first cycle it runs a four-point one-dimensional kernel along every row and writes the result into a transpose register. In the second cycle the same four butterfly units read that register and run a kernel along every column. The result appears as a registered 4x4 block.

Three one-dimensional kernels exist, and the row and column passes choose them independently. The odd-basis kernel uses the integer coefficients 12, 10, 6 and 3. The even forward kernel is the 4x4 forward core transform. The even inverse kernel is the 4x4 inverse core transform, with halving by arithmetic right shift. The mode input picks the odd kernel for both passes, the even kernel for both passes, or a mixed pair where one pass is odd and the other is even. For the even kernel, the direction input picks forward or inverse. The odd-basis outputs are left unscaled: the 1/8 factor of each pass is applied downstream. All constant products are built from shifts and adds.

Top module: `rowcol_odd_xform`

## Requirements
- R1: While reset is active and in the first cycle after it, out_valid is 0, in_ready is 1 and every out_blk element is 0.
- R2: With mode 0 and dir_inv 0, the output is Y = F·X·Fᵀ, where F has rows [1 1 1 1], [2 1 -1 -2], [1 -1 -1 1], [1 -2 2 -1]. Element (r,c) sits at flat index r*4+c in both in_blk and out_blk.
- R3: With mode 0 and dir_inv 1, every row is transformed first and then every column, each with the even inverse kernel: e=a+c, f=a-c, g=(b>>>1)-d, h=b+(d>>>1), out=[e+h, f+g, f-g, e-h].
- R4: With mode 1, the output is Y = M·X·Mᵀ, where M has rows [12 10 6 3], [10 -3 -12 -6], [6 -12 3 10], [3 -6 10 -12]. dir_inv has no effect on the result.
- R5: With mode 2, the rows use the odd kernel and the columns use the even kernel chosen by dir_inv: Y = E·X·Mᵀ.
- R6: With mode 3, the rows use the even kernel chosen by dir_inv and the columns use the odd kernel: Y = M·X·Eᵀ.
- R7: A block is accepted when in_valid and in_ready are both 1 at a clock edge. out_valid is then 1 for exactly the one cycle that starts two edges later.
- R8: in_ready is 0 in the cycle after an acceptance. in_valid is ignored in that cycle: it produces no extra result and does not disturb the block in flight.
- R9: out_blk keeps its last result unchanged in every cycle where out_valid is 0.
- R10: mode and dir_inv are sampled only at acceptance. Changing them while a block is in flight does not alter that block's result.
- R11: Inputs at full scale (IN_W-bit extremes) produce exact results in every mode, with no wrap in the OUT_W = IN_W+GUARD output.
- R12: A new block can be accepted every second cycle, so back-to-back blocks give results two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can be accepted this cycle |
| dir_inv | input | 1 | Even kernel direction: 0 forward, 1 inverse |
| mode | input | 2 | 0 even/even, 1 odd/odd, 2 rows odd and columns even, 3 rows even and columns odd |
| in_blk | input | 16*IN_W | Signed input samples, element (r,c) at bits [(r*4+c)*IN_W +: IN_W] |
| out_valid | output | 1 | One-cycle result strobe |
| out_blk | output | 16*(IN_W+GUARD) | Signed result, same element layout |

## Verification
The bound checker watches the cycle-level protocol on every cycle. It checks that each acceptance leads to a single-cycle strobe two edges later, that every strobe has a matching acceptance, that in_ready drops for exactly one cycle, and that the output holds between strobes. Only the bench scenarios can show that the numbers are right. It compares every kernel pairing and direction against an independent integer model, including impulses and full-scale patterns. It also shows that a late change of mode, or a request while busy, leaves the in-flight block untouched.

// File: rtl/rcx_pkg.sv
package rcx_pkg;
   localparam int PTS = 4;
   localparam int NEL = PTS * PTS;

   typedef enum logic [1:0] {
      KER_EVEN_INV = 2'd0,
      KER_EVEN_FWD = 2'd1,
      KER_ODD      = 2'd2,
      KER_NONE     = 2'd3
   } ker_e;

   typedef enum logic [1:0] {
      MODE_EVEN_BOTH = 2'd0,
      MODE_ODD_BOTH  = 2'd1,
      MODE_ROW_ODD   = 2'd2,
      MODE_ROW_EVEN  = 2'd3
   } mode_e;

   function automatic logic row_is_odd(input logic [1:0] m);
      return (m == MODE_ODD_BOTH) || (m == MODE_ROW_ODD);
   endfunction

   function automatic logic col_is_odd(input logic [1:0] m);
      return (m == MODE_ODD_BOTH) || (m == MODE_ROW_EVEN);
   endfunction

   function automatic ker_e pick_kernel(input logic odd, input logic inv);
      if (odd) return KER_ODD;
      return inv ? KER_EVEN_INV : KER_EVEN_FWD;
   endfunction
endpackage

// File: rtl/rcx_bfly4.sv
module rcx_bfly4
   import rcx_pkg::*;
#(
   parameter int W = 22
) (
   input  ker_e             ker,
   input  logic [4*W-1:0]   x_vec,
   output logic [4*W-1:0]   y_vec
);
   logic signed [W-1:0] xin [4];
   logic signed [W-1:0] p3 [4];
   logic signed [W-1:0] p6 [4];
   logic signed [W-1:0] p10 [4];
   logic signed [W-1:0] p12 [4];
   logic signed [W-1:0] y [4];

   // constant products from shifts and adds, one set per input point
   for (genvar i = 0; i < 4; i++) begin : g_pt
      assign xin[i] = x_vec[i*W +: W];
      assign p3[i]  = (xin[i] <<< 1) + xin[i];
      assign p6[i]  = (xin[i] <<< 2) + (xin[i] <<< 1);
      assign p10[i] = (xin[i] <<< 3) + (xin[i] <<< 1);
      assign p12[i] = (xin[i] <<< 3) + (xin[i] <<< 2);
      assign y_vec[i*W +: W] = y[i];
   end

   // even inverse stage terms
   logic signed [W-1:0] ei_e, ei_f, ei_g, ei_h;
   assign ei_e = xin[0] + xin[2];
   assign ei_f = xin[0] - xin[2];
   assign ei_g = (xin[1] >>> 1) - xin[3];
   assign ei_h = xin[1] + (xin[3] >>> 1);

   // even forward stage terms
   logic signed [W-1:0] ef_s0, ef_s1, ef_d0, ef_d1;
   assign ef_s0 = xin[0] + xin[3];
   assign ef_s1 = xin[1] + xin[2];
   assign ef_d0 = xin[0] - xin[3];
   assign ef_d1 = xin[1] - xin[2];

   always_comb begin
      case (ker)
         KER_ODD: begin
            y[0] = p12[0] + p10[1] + p6[2]  + p3[3];
            y[1] = p10[0] - p3[1]  - p12[2] - p6[3];
            y[2] = p6[0]  - p12[1] + p3[2]  + p10[3];
            y[3] = p3[0]  - p6[1]  + p10[2] - p12[3];
         end
         KER_EVEN_INV: begin
            y[0] = ei_e + ei_h;
            y[1] = ei_f + ei_g;
            y[2] = ei_f - ei_g;
            y[3] = ei_e - ei_h;
         end
         KER_EVEN_FWD: begin
            y[0] = ef_s0 + ef_s1;
            y[1] = (ef_d0 <<< 1) + ef_d1;
            y[2] = ef_s0 - ef_s1;
            y[3] = ef_d0 - (ef_d1 <<< 1);
         end
         default: begin
            y[0] = '0;
            y[1] = '0;
            y[2] = '0;
            y[3] = '0;
         end
      endcase
   end
endmodule

// File: rtl/rcx_seq.sv
module rcx_seq
   import rcx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       dir_inv,
   input  logic [1:0] mode,
   output logic       in_ready,
   output logic       busy,
   output ker_e       ker_now
);
   logic       busy_q;
   logic [1:0] mode_q;
   logic       dir_q;
   logic       take;

   assign take     = in_valid && !busy_q;
   assign in_ready = !busy_q;
   assign busy     = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         mode_q <= 2'd0;
         dir_q  <= 1'b0;
      end else begin
         busy_q <= take;
         if (take) begin
            mode_q <= mode;
            dir_q  <= dir_inv;
         end
      end
   end

   // cross-feedback kernel choice: live inputs on the row pass, latched on the column pass
   always_comb begin
      if (busy_q) ker_now = pick_kernel(col_is_odd(mode_q), dir_q);
      else        ker_now = pick_kernel(row_is_odd(mode), dir_inv);
   end
endmodule

// File: rtl/rowcol_odd_xform.sv
module rowcol_odd_xform
   import rcx_pkg::*;
#(
   parameter int IN_W  = 12,
   parameter int GUARD = 10,
   localparam int OUT_W = IN_W + GUARD
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 dir_inv,
   input  logic [1:0]           mode,
   input  logic [NEL*IN_W-1:0]  in_blk,
   output logic                 out_valid,
   output logic [NEL*OUT_W-1:0] out_blk
);
   localparam int ROW_W = PTS * OUT_W;

   if (IN_W < 2) begin : g_bad_in_w
      $error("IN_W must be at least 2");
   end
   if (GUARD < 10) begin : g_bad_guard
      $error("GUARD must cover two passes of odd-kernel gain (>= 10 bits)");
   end

   logic busy;
   ker_e ker_now;
   logic accept;

   rcx_seq seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .dir_inv  (dir_inv),
      .mode     (mode),
      .in_ready (in_ready),
      .busy     (busy),
      .ker_now  (ker_now)
   );

   assign accept = in_valid && in_ready;

   logic [OUT_W-1:0] in_ext [NEL];
   logic [OUT_W-1:0] st_q   [NEL];
   logic [OUT_W-1:0] out_q  [NEL];
   logic [ROW_W-1:0] row_in  [PTS];
   logic [ROW_W-1:0] row_out [PTS];
   logic             out_valid_q;

   for (genvar e = 0; e < NEL; e++) begin : g_elem
      assign in_ext[e] = {{GUARD{in_blk[e*IN_W + IN_W - 1]}}, in_blk[e*IN_W +: IN_W]};
      assign out_blk[e*OUT_W +: OUT_W] = out_q[e];
   end

   for (genvar r = 0; r < PTS; r++) begin : g_row
      for (genvar k = 0; k < PTS; k++) begin : g_pt
         assign row_in[r][k*OUT_W +: OUT_W] = busy ? st_q[r*PTS + k] : in_ext[r*PTS + k];
      end
      rcx_bfly4 #(.W(OUT_W)) bfly_i (
         .ker   (ker_now),
         .x_vec (row_in[r]),
         .y_vec (row_out[r])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         for (int e = 0; e < NEL; e++) begin
            st_q[e]  <= '0;
            out_q[e] <= '0;
         end
      end else begin
         out_valid_q <= busy;
         for (int r = 0; r < PTS; r++) begin
            for (int k = 0; k < PTS; k++) begin
               if (accept) st_q[k*PTS + r]  <= row_out[r][k*OUT_W +: OUT_W];
               if (busy)   out_q[k*PTS + r] <= row_out[r][k*OUT_W +: OUT_W];
            end
         end
      end
   end

   assign out_valid = out_valid_q;
endmodule

// File: rtl/rowcol_odd_xform_chk.sv
module rowcol_odd_xform_chk #(
   parameter int BLK_W = 352
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic [BLK_W-1:0] out_blk
);
   // R7
   lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> ##1 out_valid);

   // R7
   strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && in_ready, 2));

   // R7
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R12
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> in_ready);

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_blk));
endmodule

bind rowcol_odd_xform rowcol_odd_xform_chk #(.BLK_W(rcx_pkg::NEL * OUT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_blk   (out_blk)
);

// File: tb/rowcol_odd_xform_tb.sv
module rowcol_odd_xform_tb_top;
   import rcx_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int IN_W  = 12;
   localparam int GUARD = 10;
   localparam int OUT_W = IN_W + GUARD;
   localparam int NV    = 16;
   localparam int WDOG  = 20000;

   // mode, dir_inv, pattern kind, seed
   localparam int TBL [NV][4] = '{
      '{0, 0, 0, 3},  '{0, 0, 1, 11}, '{0, 1, 1, 17}, '{0, 1, 5, 6},
      '{1, 0, 1, 23}, '{1, 1, 1, 23}, '{1, 0, 5, 9},  '{2, 0, 1, 31},
      '{2, 1, 1, 37}, '{3, 0, 1, 41}, '{3, 1, 5, 2},  '{1, 0, 2, 0},
      '{1, 1, 3, 0},  '{1, 0, 4, 0},  '{2, 1, 4, 0},  '{0, 0, 4, 0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic dir_inv = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [NEL*IN_W-1:0] in_blk = '0;
   logic in_ready;
   logic out_valid;
   logic [NEL*OUT_W-1:0] out_blk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rowcol_odd_xform #(.IN_W(IN_W), .GUARD(GUARD)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .dir_inv(dir_inv), .mode(mode), .in_blk(in_blk),
      .out_valid(out_valid), .out_blk(out_blk)
   );

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == WDOG) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WDOG);
         report();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int gen_val(input int kind, input int seed, input int idx);
      case (kind)
         0: return (idx - 8) * seed;
         1: return ((seed * 1103 + idx * 2749 + idx * idx * 97) % 4096) - 2048;
         2: return -2048;
         3: return 2047;
         4: return (((idx >> 2) ^ idx) & 1) != 0 ? 2047 : -2048;
         default: return (idx == seed % 16) ? 100 : 0;
      endcase
   endfunction

   function automatic void build(input int kind, input int seed, output int x[16]);
      for (int e = 0; e < 16; e++) x[e] = gen_val(kind, seed, e);
   endfunction

   function automatic void k1d(input bit odd, input bit inv, input int v[4], output int y[4]);
      int e, f, g, h;
      if (odd) begin
         y[0] = 12*v[0] + 10*v[1] + 6*v[2] + 3*v[3];
         y[1] = 10*v[0] - 3*v[1] - 12*v[2] - 6*v[3];
         y[2] = 6*v[0] - 12*v[1] + 3*v[2] + 10*v[3];
         y[3] = 3*v[0] - 6*v[1] + 10*v[2] - 12*v[3];
      end else if (inv) begin
         e = v[0] + v[2];
         f = v[0] - v[2];
         g = (v[1] >>> 1) - v[3];
         h = v[1] + (v[3] >>> 1);
         y[0] = e + h; y[1] = f + g; y[2] = f - g; y[3] = e - h;
      end else begin
         y[0] = v[0] + v[1] + v[2] + v[3];
         y[1] = 2*v[0] + v[1] - v[2] - 2*v[3];
         y[2] = v[0] - v[1] - v[2] + v[3];
         y[3] = v[0] - 2*v[1] + 2*v[2] - v[3];
      end
   endfunction

   function automatic void ref2d(input int m, input int d, input int x[16], output int y[16]);
      int t[16];
      int v[4];
      int w[4];
      bit ro, co;
      ro = (m == 1) || (m == 2);
      co = (m == 1) || (m == 3);
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < 4; k++) v[k] = x[r*4 + k];
         k1d(ro, d != 0, v, w);
         for (int k = 0; k < 4; k++) t[r*4 + k] = w[k];
      end
      for (int c = 0; c < 4; c++) begin
         for (int k = 0; k < 4; k++) v[k] = t[k*4 + c];
         k1d(co, d != 0, v, w);
         for (int k = 0; k < 4; k++) y[k*4 + c] = w[k];
      end
   endfunction

   function automatic string req_of(input int m, input int d, input int kind);
      if (kind >= 2 && kind <= 4) return "R11";
      case (m)
         0: return (d != 0) ? "R3" : "R2";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic drive(input int m, input int d, input int x[16]);
      in_valid = 1'b1;
      mode     = 2'(m);
      dir_inv  = 1'(d);
      for (int e = 0; e < 16; e++) in_blk[e*IN_W +: IN_W] = IN_W'(x[e]);
   endtask

   task automatic cmp_blk(input string req, input int exp[16]);
      bit ok;
      int act, want, where;
      ok = 1'b1; act = 0; want = 0; where = 0;
      for (int e = 0; e < 16; e++) begin
         if (ok && int'($signed(out_blk[e*OUT_W +: OUT_W])) != exp[e]) begin
            ok = 1'b0;
            act = int'($signed(out_blk[e*OUT_W +: OUT_W]));
            want = exp[e];
            where = e;
         end
      end
      chk(ok, req, $sformatf("out_blk element %0d", where), act, want);
   endtask

   task automatic run_one(input int m, input int d, input int kind, input int seed);
      int x[16];
      int y[16];
      string req;
      req = req_of(m, d, kind);
      build(kind, seed, x);
      ref2d(m, d, x, y);
      @(negedge clk);
      chk(in_ready == 1'b1, "R12", "in_ready idle", int'(in_ready), 1);
      drive(m, d, x);
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready == 1'b0, "R8", "in_ready after accept", int'(in_ready), 0);
      chk(out_valid == 1'b0, "R7", "out_valid one cycle after accept", int'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R7", "out_valid two cycles after accept", int'(out_valid), 1);
      cmp_blk(req, y);
   endtask

   initial begin
      int xa[16];
      int xb[16];
      int ya[16];
      int yb[16];

      // R1: reset state
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
      chk(out_blk == '0, "R1", "out_blk zero after reset", 0, 0);

      // table of kernel pairings and patterns (R2..R6, R11)
      for (int i = 0; i < NV; i++) run_one(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);

      // R8 / R10 / R9: request while busy with a different mode is ignored
      build(1, 5, xa);
      ref2d(1, 0, xa, ya);
      build(1, 77, xb);
      @(negedge clk);
      drive(1, 0, xa);
      @(negedge clk);
      drive(0, 1, xb);
      chk(in_ready == 1'b0, "R8", "in_ready while busy", int'(in_ready), 0);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R10", "result strobe", int'(out_valid), 1);
      cmp_blk("R10", ya);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "no strobe from ignored request", int'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "no late strobe from ignored request", int'(out_valid), 0);
      cmp_blk("R9", ya);

      // R12: back-to-back blocks every second cycle
      build(0, 7, xa);
      ref2d(2, 0, xa, ya);
      build(5, 3, xb);
      ref2d(3, 1, xb, yb);
      @(negedge clk);
      drive(2, 0, xa);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b1, "R12", "ready as first result appears", int'(in_ready), 1);
      cmp_blk("R12", ya);
      drive(3, 1, xb);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R9", "gap between results", int'(out_valid), 0);
      cmp_blk("R9", ya);
      @(negedge clk);
      chk(out_valid == 1'b1, "R12", "second result strobe", int'(out_valid), 1);
      cmp_blk("R12", yb);

      repeat (2) @(negedge clk);
      report();
      $finish;
   end
endmodule